// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Boot-Block Lock

This block models the internal write sequencer and control pins of a NOR-style flash device. A host raises a block-erase or word-write request together with a block index. The sequencer then holds a busy interval of a fixed number of clock cycles, which stands in for the cell array, and reports its progress two ways. The first is an active-low ready/busy pin, meant to be wired as an open-drain-style wire. The second is a six-bit status word.

An erase in progress can be suspended. While it is suspended, a word write to another block may run to completion. A plain write can also be suspended and resumed. One block is the boot block; it sits at the highest or the lowest index, chosen by a parameter. Any request aimed at it is refused while the write-protect pin is low.

An active-low power-down pin puts the sequencer into deep power-down. In that state the sequencer is cleared and writes are blocked. After the pin rises, two programmable wake delays gate acceptance of new commands and the read-valid flag.

Top module: `nor_prog_sequencer`

## Requirements
- R1: An accepted erase drives readyBusyN low for exactly ERASE_CYCLES cycles, and an accepted write for exactly WRITE_CYCLES cycles. The low interval starts in the cycle after the clock edge that samples the request.
- R2: readyBusyN is high when the sequencer is idle, when an erase is suspended and no nested write runs, when a write is suspended, and while pwrdnN is low.
- R3: The status word has the following layout:
  - bit 0 is the ready flag and equals readyBusyN.
  - bit 1 is set while an erase is suspended, including while a nested write runs.
  - bit 2 is set while a write is suspended.
  - bit 3 is the erase error.
  - bit 4 is the write error.
  - bit 5 is the lock error.
  - Bits 1 and 2 are never set together.
- R4: The boot block has index NUM_BLOCKS-1 when BOOT_AT_TOP is 1, and index 0 otherwise. A request to it while protectN is low is refused: readyBusyN stays high, the lock error is set, and the erase error or write error is set to match the request type.
- R5: While protectN is high, the boot block is erased or written like any other block.
- R6: While pwrdnN is low, the sequencer state, the error bits and cmdReady are cleared asynchronously. After pwrdnN rises, cmdReady goes high after WAKE_CYCLES clock edges. Requests are ignored while cmdReady is low.
- R7: After pwrdnN rises, readValid goes high after VALID_CYCLES clock edges, and it is low while pwrdnN is low.
- R8: A suspend request during an erase or write (not in its last cycle) suspends it after that cycle. A resume request continues it. The total busy cycles still equal the operation's duration.
- R9: During a suspended erase, a write to another block runs for WRITE_CYCLES busy cycles and then returns to the suspended erase. A write to the suspended block is refused with the write error. Suspend requests are ignored during that nested write.
- R10: While busy, every request other than suspend is ignored. When idle, an erase wins over a simultaneous write. During a suspended erase, resume wins over a simultaneous write.
- R11: clearStatus clears only the three error bits. An error set in the same cycle as clearStatus stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrdnN | input | 1 | Active-low deep power-down and reset, asynchronous assertion |
| protectN | input | 1 | Active-low write protect for the boot block |
| eraseReq | input | 1 | Block-erase request |
| writeReq | input | 1 | Word-write request |
| suspendReq | input | 1 | Suspend the running operation |
| resumeReq | input | 1 | Resume the suspended operation |
| clearStatus | input | 1 | Clear the error bits of the status word |
| blockSel | input | BLK_W | Target block index |
| readyBusyN | output | 1 | Low while an erase or write is actively running |
| status | output | 6 | Status word laid out as in R3 |
| cmdReady | output | 1 | High once the command wake delay has elapsed |
| readValid | output | 1 | High once the read wake delay has elapsed |

## Verification
Directed sequences check several cases:
- plain erases and writes to ordinary blocks, which measure the busy length;
- boot-block requests with write-protect low and then high, which separate a refusal from an accepted operation;
- suspend and resume in mid-erase, with a nested write to the suspended block and then to another block, which show that the paused count is kept and that only a foreign block may be written;
- a simultaneous erase and write, and requests issued during busy or before the wake delay, which check priority and ignore rules.

Seeded random traffic then mixes all requests with power-down pulses and protect toggles. This traffic exposes ordering faults that the directed cases do not reach.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ERASE,
    SEQ_WRITE,
    SEQ_ERASE_HELD,
    SEQ_WRITE_HELD,
    SEQ_NESTED_WRITE
  } seqState_t;

  typedef struct packed {
    logic loadErase;
    logic stepErase;
    logic loadWrite;
    logic stepWrite;
    logic setEraseErr;
    logic setWriteErr;
    logic setLockErr;
  } seqStrobe_t;

endpackage

// File: rtl/nor_seq_datapath.sv
module nor_seq_datapath
  import nor_seq_pkg::*;
#(
  parameter int BLK_W        = 4,
  parameter int ERASE_CYCLES = 40,
  parameter int WRITE_CYCLES = 8,
  parameter int WAKE_CYCLES  = 5,
  parameter int VALID_CYCLES = 7
) (
  input  logic             clk,
  input  logic             pwrdnN,
  input  seqStrobe_t       strobe,
  input  logic [BLK_W-1:0] blockSel,
  input  logic             clearStatus,
  output logic             eraseLast,
  output logic             writeLast,
  output logic [BLK_W-1:0] heldBlock,
  output logic             cmdReady,
  output logic             readValid,
  output logic [2:0]       errBits
);

  localparam int MAX_OP   = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int CNT_W    = $clog2(MAX_OP + 2);
  localparam int WAKE_SAT = (WAKE_CYCLES > VALID_CYCLES) ? WAKE_CYCLES : VALID_CYCLES;
  localparam int WAKE_W   = $clog2(WAKE_SAT + 2);

  logic [1:0] loadVec;
  logic [1:0] stepVec;
  logic [1:0] lastVec;

  assign loadVec = {strobe.loadWrite, strobe.loadErase};
  assign stepVec = {strobe.stepWrite, strobe.stepErase};

  // channel 0 times the erase, channel 1 times the write
  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    localparam int LOAD_VAL = (ch == 0) ? ERASE_CYCLES : WRITE_CYCLES;
    logic [CNT_W-1:0] count;
    always_ff @(posedge clk or negedge pwrdnN) begin
      if (!pwrdnN)           count <= '0;
      else if (loadVec[ch])  count <= CNT_W'(LOAD_VAL);
      else if (stepVec[ch])  count <= count - 1'b1;
    end
    assign lastVec[ch] = (count == CNT_W'(1));
  end

  assign eraseLast = lastVec[0];
  assign writeLast = lastVec[1];

  always_ff @(posedge clk or negedge pwrdnN) begin
    if (!pwrdnN)               heldBlock <= '0;
    else if (strobe.loadErase) heldBlock <= blockSel;
  end

  logic [WAKE_W-1:0] wakeCount;
  always_ff @(posedge clk or negedge pwrdnN) begin
    if (!pwrdnN)                           wakeCount <= '0;
    else if (wakeCount < WAKE_W'(WAKE_SAT)) wakeCount <= wakeCount + 1'b1;
  end

  assign cmdReady  = (wakeCount >= WAKE_W'(WAKE_CYCLES));
  assign readValid = (wakeCount >= WAKE_W'(VALID_CYCLES));

  logic [2:0] setVec;
  assign setVec = {strobe.setLockErr, strobe.setWriteErr, strobe.setEraseErr};

  always_ff @(posedge clk or negedge pwrdnN) begin
    if (!pwrdnN) errBits <= '0;
    else         errBits <= (clearStatus ? 3'b000 : errBits) | setVec;
  end

  // R11: a clear with no new error empties the error field
  assert_clear_errors_R11: assert property (@(posedge clk) disable iff (!pwrdnN)
    (clearStatus && setVec == 3'b000) |=> (errBits == 3'b000));

  // R6: once commands are accepted they stay accepted until power-down
  assert_wake_holds_R6: assert property (@(posedge clk) disable iff (!pwrdnN)
    cmdReady |=> cmdReady);

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int BOOT_BLOCK = 15
) (
  input  logic             clk,
  input  logic             pwrdnN,
  input  logic             protectN,
  input  logic             eraseReq,
  input  logic             writeReq,
  input  logic             suspendReq,
  input  logic             resumeReq,
  input  logic [BLK_W-1:0] blockSel,
  input  logic             cmdReady,
  input  logic             eraseLast,
  input  logic             writeLast,
  input  logic [BLK_W-1:0] heldBlock,
  output seqStrobe_t       strobe,
  output logic             readyBusyN,
  output logic             eraseHeld,
  output logic             writeHeld
);

  seqState_t state, nextState;
  logic lockHit;

  assign lockHit = (blockSel == BLK_W'(BOOT_BLOCK)) && !protectN;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (cmdReady) begin
          if (eraseReq) begin
            if (lockHit) begin
              strobe.setEraseErr = 1'b1;
              strobe.setLockErr  = 1'b1;
            end else begin
              strobe.loadErase = 1'b1;
              nextState        = SEQ_ERASE;
            end
          end else if (writeReq) begin
            if (lockHit) begin
              strobe.setWriteErr = 1'b1;
              strobe.setLockErr  = 1'b1;
            end else begin
              strobe.loadWrite = 1'b1;
              nextState        = SEQ_WRITE;
            end
          end
        end
      end
      SEQ_ERASE: begin
        if (eraseLast) nextState = SEQ_IDLE;
        else begin
          strobe.stepErase = 1'b1;
          if (suspendReq) nextState = SEQ_ERASE_HELD;
        end
      end
      SEQ_WRITE: begin
        if (writeLast) nextState = SEQ_IDLE;
        else begin
          strobe.stepWrite = 1'b1;
          if (suspendReq) nextState = SEQ_WRITE_HELD;
        end
      end
      SEQ_ERASE_HELD: begin
        if (resumeReq) nextState = SEQ_ERASE;
        else if (writeReq) begin
          if (blockSel == heldBlock) begin
            strobe.setWriteErr = 1'b1;
          end else if (lockHit) begin
            strobe.setWriteErr = 1'b1;
            strobe.setLockErr  = 1'b1;
          end else begin
            strobe.loadWrite = 1'b1;
            nextState        = SEQ_NESTED_WRITE;
          end
        end
      end
      SEQ_WRITE_HELD: begin
        if (resumeReq) nextState = SEQ_WRITE;
      end
      SEQ_NESTED_WRITE: begin
        if (writeLast) nextState = SEQ_ERASE_HELD;
        else           strobe.stepWrite = 1'b1;
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge pwrdnN) begin
    if (!pwrdnN) state <= SEQ_IDLE;
    else         state <= nextState;
  end

  assign readyBusyN = !(state == SEQ_ERASE || state == SEQ_WRITE || state == SEQ_NESTED_WRITE);
  assign eraseHeld  = (state == SEQ_ERASE_HELD) || (state == SEQ_NESTED_WRITE);
  assign writeHeld  = (state == SEQ_WRITE_HELD);

  // R1: a clean erase request starts the busy interval on the next cycle
  assert_erase_starts_R1: assert property (@(posedge clk) disable iff (!pwrdnN)
    (state == SEQ_IDLE && cmdReady && eraseReq && !lockHit) |=> !readyBusyN);

  // R4: a protected boot-block erase never goes busy
  assert_boot_refused_R4: assert property (@(posedge clk) disable iff (!pwrdnN)
    (state == SEQ_IDLE && cmdReady && eraseReq && lockHit) |=> readyBusyN);

  // R6: no request leaves idle before the wake delay
  assert_wake_gate_R6: assert property (@(posedge clk) disable iff (!pwrdnN)
    (state == SEQ_IDLE && !cmdReady) |=> (state == SEQ_IDLE));

  // R8: suspend before the last cycle parks the erase with ready/busy high
  assert_erase_suspend_R8: assert property (@(posedge clk) disable iff (!pwrdnN)
    (state == SEQ_ERASE && suspendReq && !eraseLast) |=> (eraseHeld && readyBusyN));

  // R3: the two suspend flags are exclusive
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!pwrdnN)
    $onehot0({eraseHeld, writeHeld}));

  // R10: a running write ignores all but suspend
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!pwrdnN)
    (state == SEQ_WRITE && !writeLast && !suspendReq) |=> (state == SEQ_WRITE));

endmodule

// File: rtl/nor_prog_sequencer.sv
module nor_prog_sequencer
  import nor_seq_pkg::*;
#(
  parameter int NUM_BLOCKS   = 16,
  parameter bit BOOT_AT_TOP  = 1'b1,
  parameter int ERASE_CYCLES = 40,
  parameter int WRITE_CYCLES = 8,
  parameter int WAKE_CYCLES  = 5,
  parameter int VALID_CYCLES = 7,
  localparam int BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             pwrdnN,
  input  logic             protectN,
  input  logic             eraseReq,
  input  logic             writeReq,
  input  logic             suspendReq,
  input  logic             resumeReq,
  input  logic             clearStatus,
  input  logic [BLK_W-1:0] blockSel,
  output logic             readyBusyN,
  output logic [5:0]       status,
  output logic             cmdReady,
  output logic             readValid
);

  localparam int BOOT_BLOCK = BOOT_AT_TOP ? (NUM_BLOCKS - 1) : 0;

  seqStrobe_t       strobe;
  logic             eraseLast, writeLast, eraseHeld, writeHeld;
  logic [BLK_W-1:0] heldBlock;
  logic [2:0]       errBits;

  nor_seq_ctrl #(.BLK_W(BLK_W), .BOOT_BLOCK(BOOT_BLOCK)) i_ctrl (
    .clk(clk), .pwrdnN(pwrdnN), .protectN(protectN),
    .eraseReq(eraseReq), .writeReq(writeReq),
    .suspendReq(suspendReq), .resumeReq(resumeReq),
    .blockSel(blockSel), .cmdReady(cmdReady),
    .eraseLast(eraseLast), .writeLast(writeLast), .heldBlock(heldBlock),
    .strobe(strobe), .readyBusyN(readyBusyN),
    .eraseHeld(eraseHeld), .writeHeld(writeHeld)
  );

  nor_seq_datapath #(
    .BLK_W(BLK_W), .ERASE_CYCLES(ERASE_CYCLES), .WRITE_CYCLES(WRITE_CYCLES),
    .WAKE_CYCLES(WAKE_CYCLES), .VALID_CYCLES(VALID_CYCLES)
  ) i_datapath (
    .clk(clk), .pwrdnN(pwrdnN), .strobe(strobe), .blockSel(blockSel),
    .clearStatus(clearStatus), .eraseLast(eraseLast), .writeLast(writeLast),
    .heldBlock(heldBlock), .cmdReady(cmdReady), .readValid(readValid),
    .errBits(errBits)
  );

  assign status = {errBits, writeHeld, eraseHeld, readyBusyN};

endmodule

// File: tb/test_nor_prog_sequencer.sv
module test_nor_prog_sequencer;

  localparam int NB = 8, EC = 12, WC = 5, WK = 4, VC = 6, BOOT = NB - 1;
  localparam int WSAT = (WK > VC) ? WK : VC;

  logic clk = 1'b0;
  logic pwrdnN = 1'b0, protectN = 1'b1, eraseReq = 1'b0, writeReq = 1'b0;
  logic suspendReq = 1'b0, resumeReq = 1'b0, clearStatus = 1'b0;
  logic [2:0] blockSel = '0;
  logic readyBusyN, cmdReady, readValid;
  logic [5:0] status;

  always #10 clk = ~clk;

  nor_prog_sequencer #(.NUM_BLOCKS(NB), .BOOT_AT_TOP(1'b1), .ERASE_CYCLES(EC),
    .WRITE_CYCLES(WC), .WAKE_CYCLES(WK), .VALID_CYCLES(VC)) i_nor_prog_sequencer (
    .clk(clk), .pwrdnN(pwrdnN), .protectN(protectN), .eraseReq(eraseReq),
    .writeReq(writeReq), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .clearStatus(clearStatus), .blockSel(blockSel), .readyBusyN(readyBusyN),
    .status(status), .cmdReady(cmdReady), .readValid(readValid));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit prot = 1'b1;

  // reference model: 0 idle,1 erase,2 write,3 erase held,4 write held,5 nested write
  int mState = 0, mE = 0, mW = 0, mBlk = 0, mWake = 0;
  logic [2:0] mErr = '0;

  function automatic bit expBusy();
    return (mState == 1 || mState == 2 || mState == 5);
  endfunction

  function automatic logic [5:0] expStatus();
    return {mErr, mState == 4, (mState == 3 || mState == 5), !expBusy()};
  endfunction

  task automatic checkVal(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelNext();
    logic [2:0] sets = '0;
    bit acc, lock;
    if (!pwrdnN) begin
      mState = 0; mE = 0; mW = 0; mBlk = 0; mWake = 0; mErr = '0;
      return;
    end
    acc  = (mWake >= WK);
    lock = (int'(blockSel) == BOOT) && !protectN;
    if (mWake < WSAT) mWake++;
    case (mState)
      0: if (acc) begin
           if (eraseReq) begin
             if (lock) sets = 3'b101;
             else begin mState = 1; mE = EC; mBlk = blockSel; end
           end else if (writeReq) begin
             if (lock) sets = 3'b110;
             else begin mState = 2; mW = WC; end
           end
         end
      1: if (mE == 1) mState = 0; else begin mE--; if (suspendReq) mState = 3; end
      2: if (mW == 1) mState = 0; else begin mW--; if (suspendReq) mState = 4; end
      3: if (resumeReq) mState = 1;
         else if (writeReq) begin
           if (int'(blockSel) == mBlk) sets = 3'b010;
           else if (lock) sets = 3'b110;
           else begin mState = 5; mW = WC; end
         end
      4: if (resumeReq) mState = 2;
      5: if (mW == 1) mState = 3; else mW--;
      default: mState = 0;
    endcase
    mErr = (clearStatus ? 3'b000 : mErr) | sets;
  endtask

  task automatic step(input bit e, w, s, r, c, pd, input int blk);
    eraseReq = e; writeReq = w; suspendReq = s; resumeReq = r;
    clearStatus = c; pwrdnN = pd; protectN = prot; blockSel = 3'(blk);
    modelNext();
    @(posedge clk);
    @(negedge clk);
    checkVal("R1 R2 readyBusyN", readyBusyN, !expBusy());
    checkVal("R3 status flags", status[2:0], expStatus() & 6'h07);
    checkVal("R4 R9 R11 error bits", status[5:3], mErr);
    checkVal("R6 cmdReady", cmdReady, mWake >= WK);
    checkVal("R7 readValid", readValid, mWake >= VC);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 1, 0); endtask

  task automatic busyRun(output int n);
    n = readyBusyN ? 0 : 1;
    while (!readyBusyN && n < 100) begin
      idle();
      if (!readyBusyN) n++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int pdHold = 0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R6 reset state
    step(0, 0, 0, 0, 0, 0, 0);
    checkVal("R6 reset status", status, 6'b000001);
    checkVal("R2 readyBusyN in power-down", readyBusyN, 1);
    checkVal("R7 readValid in power-down", readValid, 0);
    // R6 wake delay, request before it is ignored
    step(1, 0, 0, 0, 0, 1, 2);
    checkVal("R6 early erase ignored", readyBusyN, 1);
    idle(); idle();
    checkVal("R6 cmdReady still low", cmdReady, 0);
    idle();
    checkVal("R6 cmdReady after wake", cmdReady, 1);
    idle();
    checkVal("R7 readValid still low", readValid, 0);
    idle();
    checkVal("R7 readValid after delay", readValid, 1);
    // R1 erase length
    step(1, 0, 0, 0, 0, 1, 2);
    busyRun(n);
    checkVal("R1 erase busy cycles", n, EC);
    // R4 protected boot erase
    prot = 1'b0;
    step(1, 0, 0, 0, 0, 1, BOOT);
    checkVal("R4 boot erase refused", status, 6'b101001);
    // R11 clear only errors
    step(0, 0, 0, 0, 1, 1, 0);
    checkVal("R11 clear status", status, 6'b000001);
    // R5 unprotected boot write
    prot = 1'b1;
    step(0, 1, 0, 0, 0, 1, BOOT);
    busyRun(n);
    checkVal("R5 boot write busy cycles", n, WC);
    // R8 R9 erase suspend with nested writes
    step(1, 0, 0, 0, 0, 1, 1);
    idle(); idle();
    step(0, 0, 1, 0, 0, 1, 0);
    checkVal("R8 erase suspended status", status, 6'b000011);
    step(0, 1, 0, 0, 0, 1, 1);
    checkVal("R9 write to held block refused", status, 6'b010011);
    step(0, 1, 0, 0, 1, 1, 3);
    checkVal("R9 nested write busy", status, 6'b000010);
    step(0, 0, 1, 0, 0, 1, 0);
    busyRun(n);
    checkVal("R9 nested write cycles", n, WC - 1);
    checkVal("R9 back to suspended erase", status, 6'b000011);
    step(1, 1, 0, 1, 0, 1, 4);
    busyRun(n);
    checkVal("R8 remaining erase cycles", n, EC - 3);
    // R10 erase wins over write, write during busy ignored
    step(1, 1, 0, 0, 0, 1, 5);
    step(0, 1, 0, 0, 0, 1, 6);
    busyRun(n);
    checkVal("R10 erase wins, busy ignores write", n, EC - 1);
    idle();
    checkVal("R10 no late write", readyBusyN, 1);
    // R8 write suspend and resume
    step(0, 1, 0, 0, 0, 1, 2);
    step(0, 0, 1, 0, 0, 1, 0);
    checkVal("R8 write suspended status", status, 6'b000101);
    idle();
    step(0, 0, 0, 1, 0, 1, 0);
    busyRun(n);
    checkVal("R8 write resumed cycles", n, WC - 1);
    // R6 power-down mid-erase
    step(1, 0, 0, 0, 0, 1, 3);
    prot = 1'b0;
    step(0, 1, 0, 0, 0, 1, BOOT);
    step(0, 0, 0, 0, 0, 0, 0);
    checkVal("R6 power-down clears", status, 6'b000001);
    prot = 1'b1;
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit pd;
      int blk;
      if (pdHold > 0) begin pdHold--; pd = 0; end
      else if ($urandom % 250 == 0) begin pdHold = $urandom % 3; pd = 0; end
      else pd = 1;
      prot = ($urandom % 4) != 0;
      blk  = ($urandom % 3 == 0) ? BOOT : int'($urandom % NB);
      step($urandom % 10 == 0, $urandom % 8 == 0, $urandom % 12 == 0,
           $urandom % 6 == 0, $urandom % 20 == 0, pd, blk);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule